// File: doc/BRIEF.md
# Memory-Check Command and Interrupt Controller

This block is the command front end of a memory-check coprocessor. Software loads an 8-bit command code, then writes a trigger strobe. The controller accepts that trigger only while its ready flag is high, and then decodes the command in the next cycle. It keeps a 16-bit state word: init after reset, idle once initialised, or one of several busy states, each of which stands for a RAM test kind. The test engines themselves sit outside the block. They report completion through a single done pulse and report faults through two fault pulses.

Errors fall into two classes and collect in a 16-bit error word. A rejected command is a recoverable error: software may simply issue a valid command. A fatal fault locks out every command except init until an init is accepted. The block has two interrupt flags. A transition flag is set on state changes whose category is enabled in a 2-bit mask. An error flag is set whenever any error bit is recorded. Software clears a flag by writing 0 to it, and both flags are combined into one interrupt request under a global enable.

Top module: `memchk_cmd_ctrl`

## Requirements
- R1: After reset the state reads 0x0000 (init), ready is 1, the error word is 0, both flags are 0 and the interrupt request is 0.
- R2: Command 0x10 (init) is accepted in every state, including while locked, and leaves the state at 0x0001 (idle).
- R3: Start commands 0x01, 0x02, 0x03 and 0x04 are accepted only in idle and move the state to 0x0002, 0x0003, 0x0004 and 0x0005 respectively. A done pulse in a busy state returns the state to idle. A done pulse in any other state is ignored.
- R4: Command 0xFF (stop) is accepted only in a busy state and returns the state to idle.
- R5: On the clock edge that samples a trigger while ready is 1, ready drops to 0 for exactly one cycle. The state, error word and flags change on the following edge. A trigger sampled while ready is 0 is ignored.
- R6: An undefined code, or a code that is not valid in the current state, sets error bit 0 and leaves the state unchanged. A valid command issued afterwards is accepted.
- R7: The function-ID fault pulse sets error bit 14 and the other-fault pulse sets error bit 15. From then on, every command other than init is rejected with error bit 0 until an init is accepted.
- R8: Mask bit 0 enables a change from idle into a busy state to set the transition flag. Mask bit 1 enables a change from init or from a busy state into idle to set it. A change whose mask bit is 0 leaves the flag as it was.
- R9: Error bits accumulate, and every cycle that records an error bit sets the error flag.
- R10: In the flag write, bit 0 addresses the transition flag and bit 1 addresses the error flag. Writing 0 to a bit clears that flag, and writing 0 to the error flag also clears the error word. Writing 1 has no effect. When a set and a clear of the same flag fall in the same cycle, the set wins and only the newly recorded error bits remain.
- R11: The interrupt request is 1 exactly when the enable is 1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Load the command field |
| cmd_wdata | input | 8 | Command code to load |
| trig_we | input | 1 | Trigger strobe (write of 1 to trigger) |
| mask_we | input | 1 | Load the transition mask |
| mask_wdata | input | 2 | Mask: bit 0 to-busy, bit 1 to-idle |
| ien_we | input | 1 | Load the interrupt enable |
| ien_wdata | input | 1 | Interrupt enable value |
| flag_we | input | 1 | Write to the flag pair |
| flag_wdata | input | 2 | Bit 0 transition flag, bit 1 error flag; 0 clears |
| done_i | input | 1 | Test engine finished |
| fid_err_i | input | 1 | Undefined function-ID fault |
| oth_err_i | input | 1 | Any other fault |
| ready_o | output | 1 | Command can be triggered |
| state_o | output | 16 | State word |
| error_o | output | 16 | Error word |
| tflag_o | output | 1 | Transition interrupt flag |
| eflag_o | output | 1 | Error interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. Ready stays low for exactly one cycle. The state stays put without a pending command or done pulse, and it never leaves the legal code set. A locked controller ignores non-init commands. Error bits never vanish without a clear, and the lock is raised on a fault. The flags follow their set and clear rules. Other behaviours can only be shown by the bench's scenarios against its cycle-level model: the exact busy code each start selects, a double trigger being swallowed, a set winning over a clear on the same cycle, and the recovery from a fatal fault through init.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   // Categories of state change that may raise the transition flag
   typedef struct packed {
      logic to_busy;   // idle -> any busy code
      logic to_idle;   // init or busy -> idle
   } xfer_ev_t;

   localparam int unsigned MASK_W = 2;
   localparam int unsigned FLAG_W = 2;

   localparam int unsigned MASK_BUSY_BIT = 0;
   localparam int unsigned MASK_IDLE_BIT = 1;
   localparam int unsigned FLAG_T_BIT    = 0;
   localparam int unsigned FLAG_E_BIT    = 1;

endpackage

// File: rtl/mcc_cmd_front.sv
module mcc_cmd_front #(
   parameter int unsigned CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             trig_we,
   output logic             pend_o,
   output logic [CMD_W-1:0] hold_o,
   output logic             ready_o
);

   logic [CMD_W-1:0] cmd_q;
   logic [CMD_W-1:0] hold_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cmd_we) begin
         cmd_q <= cmd_wdata;
      end
   end

   // One-cycle decode slot; a trigger during the slot is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (pend_q) begin
         pend_q <= 1'b0;
      end else if (trig_we) begin
         pend_q <= 1'b1;
         hold_q <= cmd_q;
      end
   end

   assign pend_o  = pend_q;
   assign hold_o  = hold_q;
   assign ready_o = !pend_q;

   a_r5_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !pend_q);

   a_r5_no_pend_without_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_we) |=> !pend_q);

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned ST_W        = 16,
   parameter int unsigned N_KINDS     = 4,
   parameter int unsigned CODE_INIT   = 16,
   parameter int unsigned CODE_STOP   = 255,
   parameter int unsigned CODE_START0 = 1,
   parameter int unsigned ST_INIT     = 0,
   parameter int unsigned ST_IDLE     = 1,
   parameter int unsigned ST_PROC0    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_i,
   input  logic [CMD_W-1:0] hold_i,
   input  logic             done_i,
   input  logic             lock_i,
   output logic [ST_W-1:0]  state_o,
   output logic             cmd_bad_o,
   output logic             init_hit_o,
   output xfer_ev_t         ev_o
);

   localparam logic [ST_W-1:0]  S_INIT  = ST_W'(ST_INIT);
   localparam logic [ST_W-1:0]  S_IDLE  = ST_W'(ST_IDLE);
   localparam logic [ST_W-1:0]  S_BUSY0 = ST_W'(ST_PROC0);
   localparam logic [ST_W-1:0]  S_BUSYN = ST_W'(ST_PROC0 + N_KINDS);
   localparam logic [CMD_W-1:0] C_INIT  = CMD_W'(CODE_INIT);
   localparam logic [CMD_W-1:0] C_STOP  = CMD_W'(CODE_STOP);

   logic [ST_W-1:0]    state_q, state_d;
   logic [ST_W-1:0]    start_state;
   logic [N_KINDS-1:0] start_hit;
   logic               is_idle, is_busy, nx_busy;
   logic               cmd_ok, cmd_bad, init_hit;

   // One comparator per test kind
   for (genvar k = 0; k < N_KINDS; k++) begin : g_start
      assign start_hit[k] = (hold_i == CMD_W'(CODE_START0 + k));
   end

   always_comb begin
      start_state = S_IDLE;
      for (int k = 0; k < N_KINDS; k++) begin
         if (start_hit[k]) start_state = ST_W'(ST_PROC0 + k);
      end
   end

   assign is_idle = (state_q == S_IDLE);
   assign is_busy = (state_q >= S_BUSY0) && (state_q < S_BUSYN);
   assign nx_busy = (state_d >= S_BUSY0) && (state_d < S_BUSYN);

   always_comb begin
      state_d  = state_q;
      cmd_ok   = 1'b0;
      cmd_bad  = 1'b0;
      init_hit = 1'b0;
      if (pend_i) begin
         if (hold_i == C_INIT) begin
            state_d  = S_IDLE;
            cmd_ok   = 1'b1;
            init_hit = 1'b1;
         end else if (lock_i) begin
            cmd_bad = 1'b1;
         end else if (|start_hit) begin
            if (is_idle) begin
               state_d = start_state;
               cmd_ok  = 1'b1;
            end else begin
               cmd_bad = 1'b1;
            end
         end else if (hold_i == C_STOP) begin
            if (is_busy) begin
               state_d = S_IDLE;
               cmd_ok  = 1'b1;
            end else begin
               cmd_bad = 1'b1;
            end
         end else begin
            cmd_bad = 1'b1;
         end
      end
      if (!cmd_ok && done_i && is_busy) begin
         state_d = S_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_INIT;
      else        state_q <= state_d;
   end

   assign state_o       = state_q;
   assign cmd_bad_o     = cmd_bad;
   assign init_hit_o    = init_hit;
   assign ev_o.to_busy  = is_idle && nx_busy;
   assign ev_o.to_idle  = !is_idle && (state_d == S_IDLE);

   a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_INIT) || (state_q == S_IDLE) ||
      ((state_q >= S_BUSY0) && (state_q < S_BUSYN)));

   a_r5_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_i && !done_i) |=> $stable(state_q));

   a_r2_init_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i && hold_i == C_INIT) |=> (state_q == S_IDLE));

   a_r7_locked_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i && lock_i && hold_i != C_INIT && !done_i) |=> $stable(state_q));

endmodule

// File: rtl/mcc_errlog.sv
module mcc_errlog #(
   parameter int unsigned ERR_W       = 16,
   parameter int unsigned ERR_CMD_BIT = 0,
   parameter int unsigned ERR_FID_BIT = 14,
   parameter int unsigned ERR_OTH_BIT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_bad_i,
   input  logic             fid_err_i,
   input  logic             oth_err_i,
   input  logic             init_hit_i,
   input  logic             eclr_i,
   output logic [ERR_W-1:0] error_o,
   output logic             err_set_o,
   output logic             lock_o
);

   logic [ERR_W-1:0] error_q;
   logic [ERR_W-1:0] new_bits;
   logic             lock_q;
   logic             fatal;

   always_comb begin
      new_bits              = '0;
      new_bits[ERR_CMD_BIT] = cmd_bad_i;
      new_bits[ERR_FID_BIT] = fid_err_i;
      new_bits[ERR_OTH_BIT] = oth_err_i;
   end

   assign fatal = fid_err_i || oth_err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         error_q <= '0;
         lock_q  <= 1'b0;
      end else begin
         error_q <= (eclr_i ? '0 : error_q) | new_bits;
         if (fatal)           lock_q <= 1'b1;
         else if (init_hit_i) lock_q <= 1'b0;
      end
   end

   assign error_o   = error_q;
   assign err_set_o = |new_bits;
   assign lock_o    = lock_q;

   a_r9_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!eclr_i) |=> ((error_q & $past(error_q)) == $past(error_q)));

   a_r7_lock_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (fid_err_i || oth_err_i) |=> lock_q);

endmodule

// File: rtl/mcc_irq.sv
module mcc_irq
   import mcc_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [MASK_W-1:0] mask_wdata,
   input  logic              ien_we,
   input  logic              ien_wdata,
   input  logic              flag_we,
   input  logic [FLAG_W-1:0] flag_wdata,
   input  xfer_ev_t          ev_i,
   input  logic              err_set_i,
   output logic              eclr_o,
   output logic              tflag_o,
   output logic              eflag_o,
   output logic              irq_o
);

   logic [MASK_W-1:0] mask_q;
   logic              ien_q, tflag_q, eflag_q;
   logic              tset, tclr, eclr, irq_raw;

   assign tset = (ev_i.to_busy && mask_q[MASK_BUSY_BIT]) ||
                 (ev_i.to_idle && mask_q[MASK_IDLE_BIT]);
   assign tclr = flag_we && !flag_wdata[FLAG_T_BIT];
   assign eclr = flag_we && !flag_wdata[FLAG_E_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         ien_q   <= 1'b0;
         tflag_q <= 1'b0;
         eflag_q <= 1'b0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         if (ien_we)  ien_q  <= ien_wdata;
         tflag_q <= tset      || (tflag_q && !tclr);
         eflag_q <= err_set_i || (eflag_q && !eclr);
      end
   end

   assign irq_raw = ien_q && (tflag_q || eflag_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   assign eclr_o  = eclr;
   assign tflag_o = tflag_q;
   assign eflag_o = eflag_q;

   a_r10_tflag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && !flag_wdata[FLAG_T_BIT] && !ev_i.to_busy && !ev_i.to_idle) |=> !tflag_q);

   a_r9_eflag_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      err_set_i |=> eflag_q);

   a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && !tflag_q) |=> !tflag_q);

endmodule

// File: rtl/memchk_cmd_ctrl.sv
module memchk_cmd_ctrl
   import mcc_pkg::*;
#(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned ST_W        = 16,
   parameter int unsigned ERR_W       = 16,
   parameter int unsigned N_KINDS     = 4,
   parameter int unsigned CODE_INIT   = 16,
   parameter int unsigned CODE_STOP   = 255,
   parameter int unsigned CODE_START0 = 1,
   parameter int unsigned ST_INIT     = 0,
   parameter int unsigned ST_IDLE     = 1,
   parameter int unsigned ST_PROC0    = 2,
   parameter int unsigned ERR_CMD_BIT = 0,
   parameter int unsigned ERR_FID_BIT = 14,
   parameter int unsigned ERR_OTH_BIT = 15,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             trig_we,
   input  logic             mask_we,
   input  logic [1:0]       mask_wdata,
   input  logic             ien_we,
   input  logic             ien_wdata,
   input  logic             flag_we,
   input  logic [1:0]       flag_wdata,
   input  logic             done_i,
   input  logic             fid_err_i,
   input  logic             oth_err_i,
   output logic             ready_o,
   output logic [ST_W-1:0]  state_o,
   output logic [ERR_W-1:0] error_o,
   output logic             tflag_o,
   output logic             eflag_o,
   output logic             irq_o
);

   localparam longint unsigned CMD_SPAN = 64'd1 << CMD_W;
   localparam longint unsigned ST_SPAN  = 64'd1 << ST_W;

   if (CMD_W < 2 || CMD_W > 32) begin : g_chk_cmdw
      $error("command width out of range");
   end
   if (ST_W < 2 || ST_W > 32) begin : g_chk_stw
      $error("state width out of range");
   end
   if (N_KINDS < 1) begin : g_chk_kinds
      $error("at least one test kind needed");
   end
   if (CODE_STOP >= CMD_SPAN || CODE_INIT >= CMD_SPAN ||
       CODE_START0 + N_KINDS > CMD_SPAN) begin : g_chk_codes
      $error("command code does not fit the command field");
   end
   if (ST_PROC0 + N_KINDS > ST_SPAN || ST_INIT == ST_IDLE ||
       ST_IDLE >= ST_PROC0 || ST_INIT >= ST_PROC0) begin : g_chk_states
      $error("state codes overlap or overflow");
   end
   if (ERR_CMD_BIT >= ERR_W || ERR_FID_BIT >= ERR_W || ERR_OTH_BIT >= ERR_W ||
       ERR_CMD_BIT == ERR_FID_BIT || ERR_FID_BIT == ERR_OTH_BIT ||
       ERR_CMD_BIT == ERR_OTH_BIT) begin : g_chk_errbits
      $error("error bit positions invalid");
   end

   logic             pend;
   logic [CMD_W-1:0] hold;
   logic             cmd_bad, init_hit, lock, err_set, eclr;
   xfer_ev_t         ev;

   mcc_cmd_front #(.CMD_W(CMD_W)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_wdata(cmd_wdata),
      .trig_we  (trig_we),
      .pend_o   (pend),
      .hold_o   (hold),
      .ready_o  (ready_o)
   );

   mcc_seq #(
      .CMD_W      (CMD_W),
      .ST_W       (ST_W),
      .N_KINDS    (N_KINDS),
      .CODE_INIT  (CODE_INIT),
      .CODE_STOP  (CODE_STOP),
      .CODE_START0(CODE_START0),
      .ST_INIT    (ST_INIT),
      .ST_IDLE    (ST_IDLE),
      .ST_PROC0   (ST_PROC0)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend),
      .hold_i    (hold),
      .done_i    (done_i),
      .lock_i    (lock),
      .state_o   (state_o),
      .cmd_bad_o (cmd_bad),
      .init_hit_o(init_hit),
      .ev_o      (ev)
   );

   mcc_errlog #(
      .ERR_W      (ERR_W),
      .ERR_CMD_BIT(ERR_CMD_BIT),
      .ERR_FID_BIT(ERR_FID_BIT),
      .ERR_OTH_BIT(ERR_OTH_BIT)
   ) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_bad_i (cmd_bad),
      .fid_err_i (fid_err_i),
      .oth_err_i (oth_err_i),
      .init_hit_i(init_hit),
      .eclr_i    (eclr),
      .error_o   (error_o),
      .err_set_o (err_set),
      .lock_o    (lock)
   );

   mcc_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we   (mask_we),
      .mask_wdata(mask_wdata),
      .ien_we    (ien_we),
      .ien_wdata (ien_wdata),
      .flag_we   (flag_we),
      .flag_wdata(flag_wdata),
      .ev_i      (ev),
      .err_set_i (err_set),
      .eclr_o    (eclr),
      .tflag_o   (tflag_o),
      .eflag_o   (eflag_o),
      .irq_o     (irq_o)
   );

   a_r6_bad_cmd_logged: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_bad |=> error_o[ERR_CMD_BIT]);

endmodule

// File: tb/memchk_cmd_ctrl_test.sv
module memchk_cmd_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 0, trig_we = 0, mask_we = 0, ien_we = 0, flag_we = 0;
   logic [7:0]  cmd_wdata = '0;
   logic [1:0]  mask_wdata = '0, flag_wdata = '0;
   logic        ien_wdata = 0, done_i = 0, fid_err_i = 0, oth_err_i = 0;
   logic        ready_o, tflag_o, eflag_o, irq_o;
   logic [15:0] state_o, error_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   memchk_cmd_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .trig_we(trig_we),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata),
      .flag_we(flag_we), .flag_wdata(flag_wdata),
      .done_i(done_i), .fid_err_i(fid_err_i), .oth_err_i(oth_err_i),
      .ready_o(ready_o), .state_o(state_o), .error_o(error_o),
      .tflag_o(tflag_o), .eflag_o(eflag_o), .irq_o(irq_o)
   );

   // ---------------- behavioural reference model ----------------
   int        m_state, ns;
   bit        m_pend, m_tf, m_ef, m_ien, m_lock;
   bit [7:0]  m_cmd, m_hold;
   bit [15:0] m_err, nb;
   bit [1:0]  m_mask;
   bit        ok, bad, ini, busy, tset, eclr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_pend = 0; m_tf = 0; m_ef = 0; m_ien = 0; m_lock = 0;
         m_cmd = 0; m_hold = 0; m_err = 0; m_mask = 0;
      end else begin
         busy = (m_state >= 2) && (m_state <= 5);
         ns = m_state; ok = 0; bad = 0; ini = 0;
         if (m_pend) begin
            if (m_hold == 8'h10) begin ns = 1; ok = 1; ini = 1; end
            else if (m_lock) bad = 1;
            else if (m_hold >= 1 && m_hold <= 4) begin
               if (m_state == 1) begin ns = int'(m_hold) + 1; ok = 1; end
               else bad = 1;
            end else if (m_hold == 8'hFF) begin
               if (busy) begin ns = 1; ok = 1; end
               else bad = 1;
            end else bad = 1;
         end
         if (!ok && done_i && busy) ns = 1;
         nb = '0; nb[0] = bad; nb[14] = fid_err_i; nb[15] = oth_err_i;
         tset = (m_state == 1 && ns >= 2 && ns <= 5 && m_mask[0]) ||
                (m_state != 1 && ns == 1 && m_mask[1]);
         eclr = flag_we && !flag_wdata[1];
         m_err = (eclr ? 16'h0 : m_err) | nb;
         m_ef  = (nb != 0) || (m_ef && !eclr);
         m_tf  = tset || (m_tf && !(flag_we && !flag_wdata[0]));
         if (fid_err_i || oth_err_i) m_lock = 1;
         else if (ini) m_lock = 0;
         m_state = ns;
         if (m_pend) m_pend = 0;
         else if (trig_we) begin m_pend = 1; m_hold = m_cmd; end
         if (cmd_we)  m_cmd  = cmd_wdata;
         if (mask_we) m_mask = mask_wdata;
         if (ien_we)  m_ien  = ien_wdata;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3",  "state(model)", 32'(state_o), 32'(m_state));
         chk("R5",  "ready(model)", 32'(ready_o), 32'(!m_pend));
         chk("R9",  "error(model)", 32'(error_o), 32'(m_err));
         chk("R8",  "tflag(model)", 32'(tflag_o), 32'(m_tf));
         chk("R9",  "eflag(model)", 32'(eflag_o), 32'(m_ef));
         chk("R11", "irq(model)",   32'(irq_o),   32'(m_ien && (m_tf || m_ef)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input logic [7:0] code);
      tick; cmd_we = 1; cmd_wdata = code;
      tick; cmd_we = 0; trig_we = 1;
      tick; trig_we = 0;
      tick;
   endtask

   task automatic wflags(input logic [1:0] v);
      tick; flag_we = 1; flag_wdata = v;
      tick; flag_we = 0;
   endtask

   task automatic wmask(input logic [1:0] v);
      tick; mask_we = 1; mask_wdata = v;
      tick; mask_we = 0;
   endtask

   task automatic wien(input logic v);
      tick; ien_we = 1; ien_wdata = v;
      tick; ien_we = 0;
   endtask

   task automatic pulse_done;
      tick; done_i = 1; tick; done_i = 0;
   endtask

   task automatic pulse_fid;
      tick; fid_err_i = 1; tick; fid_err_i = 0;
   endtask

   task automatic pulse_oth;
      tick; oth_err_i = 1; tick; oth_err_i = 0;
   endtask

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick;
      // R1: reset values
      chk("R1", "state", 32'(state_o), 32'h0);
      chk("R1", "ready", 32'(ready_o), 32'h1);
      chk("R1", "error", 32'(error_o), 32'h0);
      chk("R1", "irq",   32'(irq_o),   32'h0);

      wmask(2'b11);
      wien(1'b1);
      // R6: stop in init is rejected
      issue(8'hFF);
      chk("R6",  "state after stop in init", 32'(state_o), 32'h0);
      chk("R6",  "error bit0", 32'(error_o), 32'h0001);
      chk("R11", "irq on error", 32'(irq_o), 32'h1);

      // R10: clear error flag and error word
      wflags(2'b01);
      chk("R10", "error cleared", 32'(error_o), 32'h0);
      chk("R10", "eflag cleared", 32'(eflag_o), 32'h0);

      // R5 + R2: ready timing on init
      tick; cmd_we = 1; cmd_wdata = 8'h10;
      tick; cmd_we = 0; trig_we = 1;
      tick; trig_we = 0;
      chk("R5", "ready low in decode cycle", 32'(ready_o), 32'h0);
      chk("R5", "state not yet changed", 32'(state_o), 32'h0);
      tick;
      chk("R5", "ready back", 32'(ready_o), 32'h1);
      chk("R2", "init to idle", 32'(state_o), 32'h1);
      chk("R8", "to-idle flag", 32'(tflag_o), 32'h1);

      wflags(2'b10);
      chk("R10", "tflag cleared", 32'(tflag_o), 32'h0);
      issue(8'h03);
      chk("R3", "start 3 selects 0x0004", 32'(state_o), 32'h4);
      chk("R8", "to-busy flag", 32'(tflag_o), 32'h1);
      wflags(2'b10);
      pulse_done;
      chk("R3", "done returns idle", 32'(state_o), 32'h1);
      chk("R8", "to-idle flag on done", 32'(tflag_o), 32'h1);

      // R5: second trigger during decode is ignored
      tick; cmd_we = 1; cmd_wdata = 8'h01;
      tick; cmd_we = 0; trig_we = 1;
      tick;
      tick; trig_we = 0;
      tick;
      chk("R5", "double trigger state", 32'(state_o), 32'h2);
      chk("R5", "double trigger no error", 32'(error_o), 32'h0);

      issue(8'hFF);
      chk("R4", "stop to idle", 32'(state_o), 32'h1);
      pulse_done;
      chk("R3", "done in idle ignored", 32'(state_o), 32'h1);

      wmask(2'b00);
      wflags(2'b10);
      issue(8'h02);
      chk("R3", "start 2 selects 0x0003", 32'(state_o), 32'h3);
      chk("R8", "masked to-busy", 32'(tflag_o), 32'h0);
      issue(8'hFF);
      chk("R8", "masked to-idle", 32'(tflag_o), 32'h0);

      issue(8'h55);
      chk("R6", "undefined code error", 32'(error_o), 32'h0001);
      chk("R6", "undefined code state", 32'(state_o), 32'h1);
      issue(8'h04);
      chk("R6", "recover with valid start", 32'(state_o), 32'h5);
      issue(8'hFF);

      pulse_fid;
      chk("R7", "fid bit14 accumulates", 32'(error_o), 32'h4001);
      chk("R9", "eflag on fault", 32'(eflag_o), 32'h1);
      issue(8'h01);
      chk("R7", "locked start rejected", 32'(state_o), 32'h1);
      pulse_oth;
      chk("R9", "bits accumulate", 32'(error_o), 32'hC001);
      issue(8'h10);
      issue(8'h01);
      chk("R7", "unlocked by init", 32'(state_o), 32'h2);
      issue(8'hFF);

      // R10: set wins over clear in the same cycle
      tick; flag_we = 1; flag_wdata = 2'b01; fid_err_i = 1;
      tick; flag_we = 0; fid_err_i = 0;
      chk("R10", "only new bits remain", 32'(error_o), 32'h4000);
      chk("R10", "eflag set wins", 32'(eflag_o), 32'h1);
      issue(8'h10);

      wflags(2'b11);
      chk("R10", "write 1 keeps eflag", 32'(eflag_o), 32'h1);
      chk("R10", "write 1 keeps error", 32'(error_o), 32'h4000);
      wien(1'b0);
      chk("R11", "irq gated by enable", 32'(irq_o), 32'h0);
      wien(1'b1);
      chk("R11", "irq with enable", 32'(irq_o), 32'h1);

      tick(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule